// File: doc/BRIEF.md
# Banked Direct-Page Cache

This block holds a 256-byte local copy of the data a processor reaches through direct-page-relative addressing. A request marked with function code 101 forms its address from the current direct-page base in the upper byte and the request's low byte as the offset. Such a request is served from one of a small number of equal banks. Each bank covers one aligned region of memory, and its tag records which region that is. All other function codes go straight through to the memory port, uncached, in the same cycle.

When a request misses, the least-recently-used bank is taken as the victim. If the victim holds modified data, that data is first written back in full. The requested region is then refilled one byte per cycle, in ascending order from its base. A request may complete on any byte that has already arrived. A bank whose region belongs to a page other than the current direct-page base, and which holds modified data, is written back in the background. This happens in cycles when the processor is not using the memory port, so a page that has been switched away from reaches memory without the processor waiting.

The region size is B = 256 / NUM_BANKS bytes (NUM_BANKS is 2, 4 or 8). A bank's tag is the upper 16 - log2(B) bits of the address.

Top module: `dp_bank_cache`

## Requirements
- R1: A request whose function code is not 101 drives the memory port directly in the same cycle, with the address taken from cpu_addr. cpu_ready is high in that cycle, and read data is mem_rdata.
- R2: A function-code-101 request addresses {dp_base, cpu_addr[7:0]}. On a hit it completes in the cycle it is presented (cpu_ready high) and reads the most recently written value of that byte.
- R3: On a miss with a clean victim and an idle memory port, the region is read from its base upward, one byte per cycle. A request at region offset k completes k+2 cycles after it is first presented.
- R4: During a refill, bytes already fetched can be read or written and requests that hit other banks complete. A byte not yet fetched stalls the request until it arrives.
- R5: A function-code-101 write that hits updates only the cache and marks the bank modified. Memory at that address is unchanged until a write-back.
- R6: A modified bank whose page differs from dp_base is written back while the engine is idle. The write-back uses ascending addresses from the region base, and its first write is on the memory port in the cycle after dp_base changes. After it completes, memory holds the cached values.
- R7: A pass-through request has priority on the memory port. Any write-back or refill pauses for that cycle and resumes afterwards with no loss of data.
- R8: Replacement takes the least-recently-used bank. Both hits and allocations count as uses.
- R9: A modified victim is written back in full (B cycles) before its refill starts. A request at region offset k then completes B+k+2 cycles after it is presented.
- R10: After reset all banks are invalid and mem_req is low, and a direct-page read is not ready in its first cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor access request |
| cpu_fc | input | 3 | Address function code; 101 selects the cache |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | Full address for pass-through; low byte is the offset for direct-page requests |
| cpu_wdata | input | 8 | Write data |
| dp_base | input | 8 | Current direct-page base |
| cpu_ready | output | 1 | Access completes at the next rising edge |
| cpu_rdata | output | 8 | Read data, valid while cpu_ready is high |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle |

## Verification
A pass-through access and a background write-back of a switched-out page can both want the memory port in the same cycle. The bench provokes this by dirtying a bank, moving dp_base away and then issuing a pass-through read while the write-back is in progress. It judges the cycle at the ports: the pass-through address must be on the port with cpu_ready high. After the write-back drains, the bench compares the memory image against its own model. Random traffic that mixes pass-through accesses with direct-page page switches, refills and write-backs repeats this collision many times, and the final memory image is checked byte for byte.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
    localparam int unsigned CACHE_BYTES = 256;
    localparam int unsigned ADDR_W      = 16;
    localparam logic [2:0]  FC_DIRECT   = 3'b101;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_FLUSH,
        ENG_FILL
    } eng_state_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
    } mem_cmd_t;

    function automatic int unsigned region_bytes(input int unsigned banks);
        return CACHE_BYTES / banks;
    endfunction
endpackage

// File: rtl/dpc_lru.sv
module dpc_lru #(
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned BANK_W = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              touch_en,
    input  logic [BANK_W-1:0] touch_bank,
    output logic [BANK_W-1:0] victim
);
    logic [BANK_W-1:0]    age_q [NUM_BANKS];
    logic [NUM_BANKS-1:0] oldest;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_BANKS; i++)
                age_q[i] <= BANK_W'(NUM_BANKS - 1 - i);
        end else if (touch_en) begin
            for (int i = 0; i < NUM_BANKS; i++) begin
                if (BANK_W'(i) == touch_bank)
                    age_q[i] <= '0;
                else if (age_q[i] < age_q[touch_bank])
                    age_q[i] <= age_q[i] + 1'b1;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_old
        assign oldest[b] = (age_q[b] == BANK_W'(NUM_BANKS - 1));
    end

    always_comb begin
        victim = '0;
        for (int i = 0; i < NUM_BANKS; i++)
            if (oldest[i]) victim = BANK_W'(i);
    end

    // R8: the ages stay a permutation, so exactly one bank is oldest
    a_r8_one_oldest: assert property (@(posedge clk) disable iff (rst)
        $countones(oldest) == 1);
endmodule

// File: rtl/dpc_store.sv
module dpc_store #(
    parameter int unsigned DEPTH = 256,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cpu_wr,
    input  logic [IDX_W-1:0] cpu_idx,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    input  logic             eng_wr,
    input  logic [IDX_W-1:0] eng_idx,
    input  logic [7:0]       eng_wdata,
    output logic [7:0]       eng_rdata
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (cpu_wr) mem_q[cpu_idx] <= cpu_wdata;
        if (eng_wr) mem_q[eng_idx] <= eng_wdata;
    end

    assign cpu_rdata = mem_q[cpu_idx];
    assign eng_rdata = mem_q[eng_idx];

    // R4: a refill never lands on the byte the processor writes
    a_r4_no_write_clash: assert property (@(posedge clk) disable iff (rst)
        (cpu_wr && eng_wr) |-> (cpu_idx != eng_idx));
endmodule

// File: rtl/dpc_engine.sv
module dpc_engine
    import dpc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    localparam int unsigned BANK_BYTES = region_bytes(NUM_BANKS),
    localparam int unsigned OFF_W = $clog2(BANK_BYTES),
    localparam int unsigned BANK_W = $clog2(NUM_BANKS),
    localparam int unsigned TAG_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              port_busy,
    input  logic              miss,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [BANK_W-1:0] victim,
    input  logic [TAG_W-1:0]  victim_tag,
    input  logic              victim_dirty,
    input  logic              bg_valid,
    input  logic [BANK_W-1:0] bg_bank,
    input  logic [TAG_W-1:0]  bg_tag,
    input  logic [7:0]        flush_data,
    output eng_state_e        state_o,
    output logic [BANK_W-1:0] bank_o,
    output logic [OFF_W:0]    cnt_o,
    output mem_cmd_t          cmd_o,
    output logic              alloc_o,
    output logic              set_o,
    output logic [BANK_W-1:0] set_bank_o,
    output logic [TAG_W-1:0]  set_tag_o,
    output logic              flush_done_o,
    output logic              fill_wr_o,
    output logic [BANK_W+OFF_W-1:0] idx_o
);
    eng_state_e        state_q;
    logic [BANK_W-1:0] bank_q;
    logic [TAG_W-1:0]  old_tag_q, new_tag_q;
    logic              refill_q;
    logic [OFF_W:0]    cnt_q;
    logic              step, last;

    assign step = (state_q != ENG_IDLE) && !port_busy;
    assign last = (cnt_q[OFF_W-1:0] == {OFF_W{1'b1}});

    assign state_o      = state_q;
    assign bank_o       = bank_q;
    assign cnt_o        = cnt_q;
    assign idx_o        = {bank_q, cnt_q[OFF_W-1:0]};
    assign alloc_o      = (state_q == ENG_IDLE) && miss;
    assign flush_done_o = (state_q == ENG_FLUSH) && step && last;
    assign fill_wr_o    = (state_q == ENG_FILL) && step;

    always_comb begin
        set_o      = 1'b0;
        set_bank_o = bank_q;
        set_tag_o  = new_tag_q;
        if (alloc_o && !victim_dirty) begin
            set_o      = 1'b1;
            set_bank_o = victim;
            set_tag_o  = req_tag;
        end else if (flush_done_o && refill_q) begin
            set_o = 1'b1;
        end
    end

    always_comb begin
        cmd_o = '0;
        unique case (state_q)
            ENG_FLUSH: begin
                cmd_o.req   = !port_busy;
                cmd_o.we    = 1'b1;
                cmd_o.addr  = {old_tag_q, cnt_q[OFF_W-1:0]};
                cmd_o.wdata = flush_data;
            end
            ENG_FILL: begin
                cmd_o.req  = !port_busy;
                cmd_o.addr = {new_tag_q, cnt_q[OFF_W-1:0]};
            end
            default: cmd_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ENG_IDLE;
            bank_q    <= '0;
            old_tag_q <= '0;
            new_tag_q <= '0;
            refill_q  <= 1'b0;
            cnt_q     <= '0;
        end else begin
            unique case (state_q)
                ENG_IDLE: begin
                    cnt_q <= '0;
                    if (miss) begin
                        bank_q    <= victim;
                        old_tag_q <= victim_tag;
                        new_tag_q <= req_tag;
                        refill_q  <= 1'b1;
                        state_q   <= victim_dirty ? ENG_FLUSH : ENG_FILL;
                    end else if (bg_valid) begin
                        bank_q    <= bg_bank;
                        old_tag_q <= bg_tag;
                        refill_q  <= 1'b0;
                        state_q   <= ENG_FLUSH;
                    end
                end
                ENG_FLUSH: if (step) begin
                    if (last) begin
                        cnt_q   <= '0;
                        state_q <= refill_q ? ENG_FILL : ENG_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ENG_FILL: if (step) begin
                    if (last) begin
                        cnt_q   <= '0;
                        state_q <= ENG_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= ENG_IDLE;
            endcase
        end
    end

    // R7: the engine never drives the port while a pass-through owns it
    a_r7_engine_yields: assert property (@(posedge clk) disable iff (rst)
        port_busy |-> !cmd_o.req);

    // R3: a refill advances by exactly one byte per free cycle
    a_r3_fill_steps: assert property (@(posedge clk) disable iff (rst)
        (state_q == ENG_FILL && !port_busy) |=>
            (state_q == ENG_IDLE || cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dp_bank_cache.sv
module dp_bank_cache
    import dpc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cpu_req,
    input  logic [2:0]  cpu_fc,
    input  logic        cpu_we,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic [7:0]  dp_base,
    output logic        cpu_ready,
    output logic [7:0]  cpu_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata
);
    localparam int unsigned BANK_BYTES = region_bytes(NUM_BANKS);
    localparam int unsigned OFF_W      = $clog2(BANK_BYTES);
    localparam int unsigned BANK_W     = $clog2(NUM_BANKS);
    localparam int unsigned TAG_W      = ADDR_W - OFF_W;

    logic [TAG_W-1:0]     tag_q [NUM_BANKS];
    logic [NUM_BANKS-1:0] valid_q, dirty_q, hit_vec, bg_vec;

    logic              is_dp, pass, any_hit, blocked, dp_done, miss;
    logic [15:0]       dp_addr;
    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  req_off;
    logic [BANK_W-1:0] hit_bank, victim, bg_bank;
    logic              bg_valid;
    logic [7:0]        store_cpu_rdata, store_eng_rdata;

    eng_state_e        eng_state;
    logic [BANK_W-1:0] eng_bank, set_bank;
    logic [OFF_W:0]    eng_cnt;
    mem_cmd_t          eng_cmd;
    logic              alloc, set_en, flush_done, fill_wr;
    logic [TAG_W-1:0]  set_tag;
    logic [BANK_W+OFF_W-1:0] eng_idx;

    assign is_dp   = cpu_req && (cpu_fc == FC_DIRECT);
    assign pass    = cpu_req && (cpu_fc != FC_DIRECT);
    assign dp_addr = {dp_base, cpu_addr[7:0]};
    assign req_tag = dp_addr[15:OFF_W];
    assign req_off = dp_addr[OFF_W-1:0];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign hit_vec[b] = valid_q[b] && (tag_q[b] == req_tag);
        assign bg_vec[b]  = valid_q[b] && dirty_q[b] &&
                            (tag_q[b][TAG_W-1 -: 8] != dp_base);
    end

    always_comb begin
        hit_bank = '0;
        bg_bank  = '0;
        for (int i = NUM_BANKS - 1; i >= 0; i--) begin
            if (hit_vec[i]) hit_bank = BANK_W'(i);
            if (bg_vec[i])  bg_bank  = BANK_W'(i);
        end
    end

    assign any_hit  = |hit_vec;
    assign bg_valid = |bg_vec;
    assign blocked  = (eng_bank == hit_bank) &&
                      ((eng_state == ENG_FLUSH) ||
                       (eng_state == ENG_FILL && {1'b0, req_off} >= eng_cnt));
    assign dp_done  = is_dp && any_hit && !blocked;
    assign miss     = is_dp && !any_hit;

    assign cpu_ready = pass || dp_done;
    assign cpu_rdata = pass ? mem_rdata : store_cpu_rdata;

    always_comb begin
        if (pass) begin
            mem_req   = 1'b1;
            mem_we    = cpu_we;
            mem_addr  = cpu_addr;
            mem_wdata = cpu_wdata;
        end else begin
            mem_req   = eng_cmd.req;
            mem_we    = eng_cmd.we;
            mem_addr  = eng_cmd.addr;
            mem_wdata = eng_cmd.wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else begin
            if (alloc) valid_q[victim] <= 1'b0;
            if (set_en) begin
                tag_q[set_bank]   <= set_tag;
                valid_q[set_bank] <= 1'b1;
                dirty_q[set_bank] <= 1'b0;
            end
            if (flush_done) dirty_q[eng_bank] <= 1'b0;
            if (dp_done && cpu_we) dirty_q[hit_bank] <= 1'b1;
        end
    end

    dpc_lru #(.NUM_BANKS(NUM_BANKS)) u_lru (
        .clk        (clk),
        .rst        (rst),
        .touch_en   (alloc || dp_done),
        .touch_bank (alloc ? victim : hit_bank),
        .victim     (victim)
    );

    dpc_store #(.DEPTH(CACHE_BYTES)) u_store (
        .clk       (clk),
        .rst       (rst),
        .cpu_wr    (dp_done && cpu_we),
        .cpu_idx   ({hit_bank, req_off}),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (store_cpu_rdata),
        .eng_wr    (fill_wr),
        .eng_idx   (eng_idx),
        .eng_wdata (mem_rdata),
        .eng_rdata (store_eng_rdata)
    );

    dpc_engine #(.NUM_BANKS(NUM_BANKS)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .port_busy    (pass),
        .miss         (miss),
        .req_tag      (req_tag),
        .victim       (victim),
        .victim_tag   (tag_q[victim]),
        .victim_dirty (valid_q[victim] && dirty_q[victim]),
        .bg_valid     (bg_valid),
        .bg_bank      (bg_bank),
        .bg_tag       (tag_q[bg_bank]),
        .flush_data   (store_eng_rdata),
        .state_o      (eng_state),
        .bank_o       (eng_bank),
        .cnt_o        (eng_cnt),
        .cmd_o        (eng_cmd),
        .alloc_o      (alloc),
        .set_o        (set_en),
        .set_bank_o   (set_bank),
        .set_tag_o    (set_tag),
        .flush_done_o (flush_done),
        .fill_wr_o    (fill_wr),
        .idx_o        (eng_idx)
    );

    // R2: a region lives in at most one bank
    a_r2_single_hit: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    // R6: a finished write-back leaves its bank clean
    a_r6_flush_cleans: assert property (@(posedge clk) disable iff (rst)
        flush_done |=> !dirty_q[$past(eng_bank)]);

    // R9: a modified victim goes to write-back before any refill
    a_r9_dirty_first: assert property (@(posedge clk) disable iff (rst)
        (alloc && valid_q[victim] && dirty_q[victim]) |=> eng_state == ENG_FLUSH);

    // R5: a cached write never appears on the memory port in its own cycle
    a_r5_write_stays: assert property (@(posedge clk) disable iff (rst)
        (dp_done && cpu_we) |-> !(mem_req && mem_we && mem_addr == dp_addr));
endmodule

// File: tb/test_dp_bank_cache.sv
`timescale 1ns/1ps
module test_dp_bank_cache;
    localparam int NB = 4;
    localparam int B  = 256 / NB;
    localparam logic [2:0] FC_DP   = 3'b101;
    localparam logic [2:0] FC_DATA = 3'b100;

    logic        clk = 1'b0, rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [2:0]  cpu_fc = 3'b000;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0, dp_base = '0;
    logic        cpu_ready, mem_req, mem_we;
    logic [7:0]  cpu_rdata, mem_wdata, mem_rdata;
    logic [15:0] mem_addr;

    logic [7:0] mem [4096];
    logic [7:0] ref_mem [4096];
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    dp_bank_cache #(.NUM_BANKS(NB)) i_dp_bank_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_fc(cpu_fc), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .dp_base(dp_base),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    assign mem_rdata = mem[mem_addr[11:0]];
    always @(posedge clk) if (mem_req && mem_we) mem[mem_addr[11:0]] <= mem_wdata;

    function automatic logic [7:0] seed_byte(input int a);
        return 8'(a) ^ 8'((a >> 8) * 8'h35) ^ 8'h5A;
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; cpu_req = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
    endtask

    task automatic access(input logic [2:0] fc, input logic [7:0] dp, input bit we,
                          input logic [15:0] addr, input logic [7:0] wd,
                          output logic [7:0] rd, output int lat);
        @(negedge clk);
        cpu_req = 1'b1; cpu_fc = fc; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        if (fc == FC_DP) dp_base = dp;
        #1;
        lat = 0;
        while (!cpu_ready && lat < 3000) begin
            @(negedge clk); #1; lat++;
        end
        if (lat >= 3000) chk("R2", "access timeout", lat, 0);
        rd = cpu_rdata;
        @(posedge clk); #1;
        cpu_req = 1'b0;
    endtask

    task automatic dp_op(input logic [7:0] dp, input logic [7:0] off, input bit we,
                         input logic [7:0] wd, output int lat);
        logic [7:0] rd;
        int a;
        a = {dp[3:0], off};
        access(FC_DP, dp, we, {8'h00, off}, wd, rd, lat);
        if (we) ref_mem[a] = wd;
        else chk("R2", $sformatf("dp read %03h", a), rd, ref_mem[a]);
    endtask

    task automatic pt_op(input logic [15:0] addr, input bit we, input logic [7:0] wd);
        logic [7:0] rd;
        int lat;
        access(FC_DATA, dp_base, we, addr, wd, rd, lat);
        chk("R1", "pass-through latency", lat, 0);
        if (we) ref_mem[addr[11:0]] = wd;
        else chk("R1", "pass-through read", rd, ref_mem[addr[11:0]]);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = seed_byte(i);
    end

    initial begin
        int lat, bad;
        do_reset();

        // R10: reset state
        @(negedge clk);
        cpu_req = 1'b1; cpu_fc = FC_DP; cpu_we = 1'b0; cpu_addr = 16'h0000; dp_base = 8'h00;
        #1;
        chk("R10", "ready after reset", int'(cpu_ready), 0);
        chk("R10", "mem_req after reset", int'(mem_req), 0);
        cpu_req = 1'b0;

        // R3: clean miss latency, then R2 hits
        dp_op(8'h01, 8'h05, 0, 0, lat);
        chk("R3", "miss latency off 5", lat, 7);
        dp_op(8'h01, 8'h05, 0, 0, lat);
        chk("R2", "hit latency", lat, 0);
        repeat (70) @(posedge clk);
        dp_op(8'h01, 8'h3F, 0, 0, lat);
        chk("R2", "hit latency end of region", lat, 0);

        // R4: partially refilled region
        dp_op(8'h02, 8'h40, 0, 0, lat);
        chk("R4", "first byte latency", lat, 2);
        dp_op(8'h02, 8'h7F, 0, 0, lat);
        chk("R4", "last byte waits for refill", lat, 62);

        // R5: write stays in cache
        dp_op(8'h02, 8'h41, 1, 8'hA7, lat);
        chk("R5", "write hit latency", lat, 0);
        chk("R5", "memory untouched", mem[12'h241], seed_byte(12'h241));
        dp_op(8'h02, 8'h41, 0, 0, lat);

        // R6 + R7: background write-back collides with pass-through
        @(negedge clk); dp_base = 8'h03;
        @(negedge clk); #1;
        chk("R6", "write-back starts", int'(mem_req && mem_we), 1);
        chk("R6", "write-back address", mem_addr, 16'h0240);
        cpu_req = 1'b1; cpu_fc = FC_DATA; cpu_we = 1'b0; cpu_addr = 16'h0900;
        #1;
        chk("R7", "pass-through ready during write-back", int'(cpu_ready), 1);
        chk("R7", "pass-through owns port", mem_addr, 16'h0900);
        chk("R7", "pass-through read data", cpu_rdata, ref_mem[12'h900]);
        @(posedge clk); #1 cpu_req = 1'b0;
        repeat (80) @(posedge clk);
        chk("R6", "written-back byte", mem[12'h241], 8'hA7);
        chk("R7", "paused write-back complete", mem[12'h27F], seed_byte(12'h27F));

        // R8: least-recently-used replacement
        do_reset();
        dp_op(8'h00, 8'h00, 0, 0, lat);
        dp_op(8'h00, 8'h40, 0, 0, lat);
        dp_op(8'h00, 8'h80, 0, 0, lat);
        dp_op(8'h00, 8'hC0, 0, 0, lat);
        repeat (70) @(posedge clk);
        dp_op(8'h00, 8'h80, 0, 0, lat);
        dp_op(8'h00, 8'h00, 0, 0, lat);
        dp_op(8'h00, 8'hC0, 0, 0, lat);
        dp_op(8'h00, 8'h40, 0, 0, lat);
        chk("R8", "warm hit", lat, 0);
        dp_op(8'h01, 8'h00, 0, 0, lat);
        chk("R8", "new region miss", lat, 2);
        dp_op(8'h00, 8'h00, 0, 0, lat);
        chk("R4", "other bank hits during refill", lat, 0);
        dp_op(8'h00, 8'hC0, 0, 0, lat);
        chk("R8", "recent region kept", lat, 0);
        dp_op(8'h00, 8'h40, 0, 0, lat);
        chk("R8", "recent region kept 2", lat, 0);
        repeat (70) @(posedge clk);
        dp_op(8'h00, 8'h80, 0, 0, lat);
        chk("R8", "least-recent region was evicted", lat, 2);

        // R9: modified victim
        do_reset();
        dp_op(8'h00, 8'h05, 1, 8'h3C, lat);
        chk("R4", "write waits for its byte", lat, 7);
        dp_op(8'h00, 8'h40, 0, 0, lat);
        dp_op(8'h00, 8'h80, 0, 0, lat);
        dp_op(8'h00, 8'hC0, 0, 0, lat);
        repeat (70) @(posedge clk);
        dp_op(8'h05, 8'h10, 0, 0, lat);
        chk("R9", "dirty miss latency", lat, B + 16 + 2);
        chk("R9", "victim written back", mem[12'h005], 8'h3C);

        // random traffic
        do_reset();
        void'($urandom(32'd20240611));
        begin
            logic [7:0] cur_dp;
            cur_dp = 8'h00;
            for (int n = 0; n < 500; n++) begin
                if ($urandom % 8 == 0) begin
                    pt_op(16'h0800 | 16'($urandom % 2048), bit'($urandom % 2), 8'($urandom));
                end else begin
                    if ($urandom % 20 == 0) cur_dp = 8'($urandom % 8);
                    dp_op(cur_dp, 8'($urandom), bit'($urandom % 3 == 0), 8'($urandom), lat);
                end
            end
        end

        // R6: every switched-out page reaches memory
        @(negedge clk); dp_base = 8'h08;
        repeat (400) @(posedge clk);
        bad = 0;
        for (int i = 0; i < 2048; i++) if (mem[i] != ref_mem[i]) bad++;
        chk("R6", "final memory image mismatches", bad, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule